// File: doc/BRIEF.md
# Pipeline Stall and Flush Controller

This block decides, cycle by cycle, whether a five-stage in-order integer pipeline must freeze its front end or discard a wrongly fetched instruction. The pipeline has no bypass paths, so an instruction in decode can only take its operands from the register file. The register file hands a value written in writeback straight to a read in the same cycle. A consumer therefore waits while its producer sits in execute or memory, and goes ahead once the producer reaches writeback. Memory accesses always finish in one cycle, so the memory stage never causes a stall of its own.

Branches are resolved in decode. Fetch always continues with the sequential instruction. When a branch in decode is taken, the one instruction fetched behind it is squashed into a bubble, and the PC is loaded with the target. A branch whose operands are still in flight stalls like any other consumer. Its taken decision only acts in the cycle it actually leaves decode. After it resolves, the branch itself still flows down to writeback.

Each cycle the controller takes the decode-stage source indices and their use flags, the destination index and write enable of the execute and memory stages, and the branch status of decode. It returns four strobes that the datapath applies: hold the PC, hold the fetch/decode register, inject a bubble into execute, and squash the fetch/decode register.

Top module: `pipe_stall_flush`

## Requirements
- R1: When decode holds a valid instruction, a used source index is nonzero, and it equals the destination of a register-writing instruction in execute, `holdPc` is 1 in that same cycle.
- R2: The same match against a register-writing instruction in memory also makes `holdPc` 1.
- R3: A source whose producer is in neither execute nor memory (it is in writeback or already retired) causes no stall, because the same-cycle write-through of the register file supplies the value.
- R4: Index 0 never matches: a source of 0 causes no stall, even when execute or memory reports a write to index 0.
- R5: A source with its use flag at 0, or a matching stage with its write enable at 0, causes no stall.
- R6: `holdPc`, `holdFd` and `bubbleEx` are always equal: a stall freezes the PC and the fetch/decode register and turns the execute input into a bubble in the same cycle.
- R7: A valid, taken branch in decode with no stall sets `squashFd` for that cycle and leaves all three hold strobes at 0.
- R8: A stall has priority over a flush. While decode stalls, `squashFd` stays 0 even if the branch there reports taken.
- R9: A branch that is not taken never sets `squashFd`.
- R10: With no valid instruction in decode (including while reset is active), all four strobes are 0.
- R11: The strobes follow a fixed pattern in the loop ld x9,(x2); mul x4,x9,x9; ld x10,(x1); add x10,x10,x4; sd x10,(x1); addi x2; addi x1; sub x5,x2,x3; bnez x5. Decode cycles are counted from 0 at the load of each iteration, with a period of 19. The stall cycles are offsets 1, 2, 5, 6, 8, 9, 13, 15 and 16. The squash cycle is offset 17, on every iteration except the last.
- R12: For N iterations, the last branch reaches writeback in cycle 19*N+3, counting the first fetch as cycle 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used by the bound property checker |
| rstN | input | 1 | Active-low reset, used by the bound property checker |
| decValid | input | 1 | Decode stage holds a real instruction |
| decSrcIdx | input | NUM_SRC*IDX_W | Source register indices of the decode instruction |
| decSrcUse | input | NUM_SRC | Per-source flag: the operand is actually read |
| decIsBranch | input | 1 | Decode instruction is a conditional branch |
| decBrTaken | input | 1 | Branch condition evaluated in decode is true |
| exRd | input | IDX_W | Destination index of the execute-stage instruction |
| exWe | input | 1 | Execute-stage instruction writes a register |
| memRd | input | IDX_W | Destination index of the memory-stage instruction |
| memWe | input | 1 | Memory-stage instruction writes a register |
| holdPc | output | 1 | Keep the PC unchanged this cycle |
| holdFd | output | 1 | Keep the fetch/decode register unchanged this cycle |
| bubbleEx | output | 1 | Load a bubble with all write enables cleared into execute |
| squashFd | output | 1 | Replace the fetch/decode register with a bubble |

## Verification
The properties check on every cycle the local rules that can be read from a single cycle of the ports. These are: a live match in execute or memory forces a stall, index 0 and unused sources never stall, the three hold strobes move together, stall wins over squash, a squash is only ever caused by a valid taken branch, and an empty decode slot is quiet. What no single-cycle property can show is the timing of the whole loop. That covers how stalls line up with producer distance once earlier stalls have stretched the schedule, a branch waiting on its own operand before it flushes, and the total cycle count. Only the bench's pipeline scenario shows these, by feeding the strobes back into its stage model and comparing against the hand-derived chart.

// File: rtl/pipe_hazard_pkg.sv
`timescale 1ns/1ps
package pipe_hazard_pkg;

  // Strobes passed from the hazard control to the pipeline registers.
  typedef struct packed {
    logic holdPc;    // PC keeps its value
    logic holdFd;    // fetch/decode register keeps its value
    logic bubbleEx;  // execute input becomes a bubble
    logic squashFd;  // fetch/decode register becomes a bubble
  } hazStrobes_t;

endpackage

// File: rtl/pipe_hazard_cmp.sv
`timescale 1ns/1ps
// Operand comparators: one pair of match lines per decode source.
module pipe_hazard_cmp #(
  parameter int IDX_W   = 5,
  parameter int NUM_SRC = 2
) (
  input  logic [NUM_SRC-1:0][IDX_W-1:0] srcIdx,
  input  logic [NUM_SRC-1:0]            srcUse,
  input  logic [IDX_W-1:0]              exRd,
  input  logic                          exWe,
  input  logic [IDX_W-1:0]              memRd,
  input  logic                          memWe,
  output logic [NUM_SRC-1:0]            hitEx,
  output logic [NUM_SRC-1:0]            hitMem
);

  localparam logic [IDX_W-1:0] ZERO_IDX = '0;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    logic liveSrc;
    assign liveSrc   = srcUse[s] && (srcIdx[s] != ZERO_IDX);
    assign hitEx[s]  = liveSrc && exWe  && (exRd  == srcIdx[s]);
    assign hitMem[s] = liveSrc && memWe && (memRd == srcIdx[s]);
  end

endmodule

// File: rtl/pipe_hazard_ctl.sv
`timescale 1ns/1ps
// Control: turns operand matches and branch status into pipeline strobes.
module pipe_hazard_ctl
  import pipe_hazard_pkg::*;
#(
  parameter int NUM_SRC = 2
) (
  input  logic               decValid,
  input  logic               decIsBranch,
  input  logic               decBrTaken,
  input  logic [NUM_SRC-1:0] hitEx,
  input  logic [NUM_SRC-1:0] hitMem,
  output hazStrobes_t        strobes
);

  logic stallReq;
  logic flushReq;

  // Producer still in execute or memory: wait for writeback pass-through.
  assign stallReq = decValid && ((|hitEx) || (|hitMem));

  // A branch only redirects in the cycle it leaves decode.
  assign flushReq = decValid && decIsBranch && decBrTaken;

  always_comb begin
    strobes          = '0;
    strobes.holdPc   = stallReq;
    strobes.holdFd   = stallReq;
    strobes.bubbleEx = stallReq;
    strobes.squashFd = flushReq && !stallReq;
  end

endmodule

// File: rtl/pipe_stall_flush.sv
`timescale 1ns/1ps
// Top: stall and flush controller for a bypass-free five-stage pipeline.
module pipe_stall_flush
  import pipe_hazard_pkg::*;
#(
  parameter int IDX_W   = 5,
  parameter int NUM_SRC = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          decValid,
  input  logic [NUM_SRC-1:0][IDX_W-1:0] decSrcIdx,
  input  logic [NUM_SRC-1:0]            decSrcUse,
  input  logic                          decIsBranch,
  input  logic                          decBrTaken,
  input  logic [IDX_W-1:0]              exRd,
  input  logic                          exWe,
  input  logic [IDX_W-1:0]              memRd,
  input  logic                          memWe,
  output logic                          holdPc,
  output logic                          holdFd,
  output logic                          bubbleEx,
  output logic                          squashFd
);

  logic [NUM_SRC-1:0] hitEx;
  logic [NUM_SRC-1:0] hitMem;
  hazStrobes_t        strobes;

  pipe_hazard_cmp #(
    .IDX_W  (IDX_W),
    .NUM_SRC(NUM_SRC)
  ) u_cmp (
    .srcIdx(decSrcIdx),
    .srcUse(decSrcUse),
    .exRd  (exRd),
    .exWe  (exWe),
    .memRd (memRd),
    .memWe (memWe),
    .hitEx (hitEx),
    .hitMem(hitMem)
  );

  pipe_hazard_ctl #(
    .NUM_SRC(NUM_SRC)
  ) u_ctl (
    .decValid   (decValid),
    .decIsBranch(decIsBranch),
    .decBrTaken (decBrTaken),
    .hitEx      (hitEx),
    .hitMem     (hitMem),
    .strobes    (strobes)
  );

  assign holdPc   = strobes.holdPc;
  assign holdFd   = strobes.holdFd;
  assign bubbleEx = strobes.bubbleEx;
  assign squashFd = strobes.squashFd;

endmodule

// File: rtl/pipe_stall_flush_chk.sv
`timescale 1ns/1ps
// Property checker bound to the controller top.
module pipe_stall_flush_chk #(
  parameter int IDX_W   = 5,
  parameter int NUM_SRC = 2
) (
  input logic                          clk,
  input logic                          rstN,
  input logic                          decValid,
  input logic [NUM_SRC-1:0][IDX_W-1:0] decSrcIdx,
  input logic [NUM_SRC-1:0]            decSrcUse,
  input logic                          decIsBranch,
  input logic                          decBrTaken,
  input logic [IDX_W-1:0]              exRd,
  input logic                          exWe,
  input logic [IDX_W-1:0]              memRd,
  input logic                          memWe,
  input logic                          holdPc,
  input logic                          holdFd,
  input logic                          bubbleEx,
  input logic                          squashFd
);

  localparam logic [IDX_W-1:0] NULL_REG = '0;

  logic [NUM_SRC-1:0] readsReal;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_chk
    assign readsReal[s] = decSrcUse[s] && (decSrcIdx[s] != NULL_REG);

    a_r1_ex_match_stalls: assert property (@(posedge clk) disable iff (!rstN)
      (decValid && readsReal[s] && exWe && (exRd == decSrcIdx[s])) |-> (holdPc && !squashFd));

    a_r2_mem_match_stalls: assert property (@(posedge clk) disable iff (!rstN)
      (decValid && readsReal[s] && memWe && (memRd == decSrcIdx[s])) |-> (holdPc && !squashFd));
  end

  a_r4_null_sources_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (readsReal == '0) |-> !holdPc);

  a_r6_hold_group_set: assert property (@(posedge clk) disable iff (!rstN)
    holdPc |-> (holdFd && bubbleEx));

  a_r6_hold_group_clear: assert property (@(posedge clk) disable iff (!rstN)
    !holdPc |-> (!holdFd && !bubbleEx));

  a_r7_squash_cause: assert property (@(posedge clk) disable iff (!rstN)
    squashFd |-> (decValid && decIsBranch && decBrTaken));

  a_r8_stall_beats_squash: assert property (@(posedge clk) disable iff (!rstN)
    holdPc |-> !squashFd);

  a_r10_empty_decode_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !decValid |-> (!holdPc && !squashFd));

endmodule

bind pipe_stall_flush pipe_stall_flush_chk #(
  .IDX_W  (IDX_W),
  .NUM_SRC(NUM_SRC)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .decValid   (decValid),
  .decSrcIdx  (decSrcIdx),
  .decSrcUse  (decSrcUse),
  .decIsBranch(decIsBranch),
  .decBrTaken (decBrTaken),
  .exRd       (exRd),
  .exWe       (exWe),
  .memRd      (memRd),
  .memWe      (memWe),
  .holdPc     (holdPc),
  .holdFd     (holdFd),
  .bubbleEx   (bubbleEx),
  .squashFd   (squashFd)
);

// File: tb/test_pipe_stall_flush.sv
`timescale 1ns/1ps
module test_pipe_stall_flush;

  localparam int IDX_W    = 5;
  localparam int NUM_SRC  = 2;
  localparam int PERIOD   = 19;
  localparam int BR_SLOT  = 8;
  localparam int WATCHDOG = 100000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic decValid = 1'b0;
  logic [NUM_SRC-1:0][IDX_W-1:0] decSrcIdx = '0;
  logic [NUM_SRC-1:0] decSrcUse = '0;
  logic decIsBranch = 1'b0;
  logic decBrTaken = 1'b0;
  logic [IDX_W-1:0] exRd = '0;
  logic exWe = 1'b0;
  logic [IDX_W-1:0] memRd = '0;
  logic memWe = 1'b0;
  logic holdPc, holdFd, bubbleEx, squashFd;

  int errors = 0;
  int checks = 0;

  typedef struct {
    int cyc;
    int stall;
    int squash;
  } expItem_t;
  expItem_t expQ[$];

  always #2 clk = ~clk;

  pipe_stall_flush #(.IDX_W(IDX_W), .NUM_SRC(NUM_SRC)) i_pipe_stall_flush (
    .clk(clk), .rstN(rstN), .decValid(decValid), .decSrcIdx(decSrcIdx),
    .decSrcUse(decSrcUse), .decIsBranch(decIsBranch), .decBrTaken(decBrTaken),
    .exRd(exRd), .exWe(exWe), .memRd(memRd), .memWe(memWe),
    .holdPc(holdPc), .holdFd(holdFd), .bubbleEx(bubbleEx), .squashFd(squashFd)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Strobes packed as {holdPc, holdFd, bubbleEx, squashFd}.
  function automatic int outs();
    return int'({28'd0, holdPc, holdFd, bubbleEx, squashFd});
  endfunction

  task automatic directed(input string req, input int v, input int s0, input int u0,
                          input int s1, input int u1, input int br, input int tk,
                          input int er, input int ew, input int mr, input int mw,
                          input int expOut);
    @(negedge clk);
    decValid = (v != 0);
    decSrcIdx[0] = IDX_W'(s0); decSrcUse[0] = (u0 != 0);
    decSrcIdx[1] = IDX_W'(s1); decSrcUse[1] = (u1 != 0);
    decIsBranch = (br != 0); decBrTaken = (tk != 0);
    exRd = IDX_W'(er); exWe = (ew != 0);
    memRd = IDX_W'(mr); memWe = (mw != 0);
    #1;
    chk(req, outs(), expOut);
  endtask

  // Loop program, slots 0..8; slot 9 is a filler with no operands.
  function automatic int rdOf(input int i);
    case (i)
      0: return 9;  1: return 4;  2: return 10; 3: return 10;
      5: return 2;  6: return 1;  7: return 5;
      default: return 0;
    endcase
  endfunction

  function automatic int srcA(input int i);
    case (i)
      0: return 2; 1: return 9; 2: return 1; 3: return 10; 4: return 1;
      5: return 2; 6: return 1; 7: return 2; 8: return 5;
      default: return 0;
    endcase
  endfunction

  function automatic int srcB(input int i);
    case (i)
      1: return 9; 3: return 4; 4: return 10; 7: return 3;
      default: return 0;
    endcase
  endfunction

  // Driver: push the expected strobe chart (R11) for n iterations.
  task automatic pushExpect(input int n);
    for (int c = 1; c <= PERIOD * n; c++) begin
      expItem_t it;
      it.cyc = c; it.stall = 0; it.squash = 0;
      if (c >= 2) begin
        int off, k;
        off = (c - 2) % PERIOD;
        k = (c - 2) / PERIOD;
        it.stall = (off == 1 || off == 2 || off == 5 || off == 6 || off == 8 ||
                    off == 9 || off == 13 || off == 15 || off == 16) ? 1 : 0;
        it.squash = (off == 17 && k < n - 1) ? 1 : 0;
      end
      expQ.push_back(it);
    end
  endtask

  // Monitor: pop one expectation and compare with the live strobes.
  task automatic monitorPop();
    expItem_t it;
    if (expQ.size() > 0) begin
      it = expQ.pop_front();
      chk($sformatf("R11 stall at cycle %0d", it.cyc), int'({31'd0, holdPc}), it.stall);
      chk($sformatf("R11 squash at cycle %0d", it.cyc), int'({31'd0, squashFd}), it.squash);
    end
  endtask

  task automatic runLoop(input int n);
    int fd = -1, ex = -1, mem = -1, wb = -1;
    int pc = 0, brDone = 0, brWb = 0, cyc = 0, doneCyc = 0;
    pushExpect(n);
    while (doneCyc == 0 && cyc < 5000) begin
      @(negedge clk);
      cyc++;
      if (wb == BR_SLOT) begin
        brWb++;
        if (brWb == n) doneCyc = cyc;
      end
      decValid = (fd >= 0);
      decSrcIdx[0] = IDX_W'(srcA(fd));
      decSrcUse[0] = (fd >= 0 && fd <= BR_SLOT);
      decSrcIdx[1] = IDX_W'(srcB(fd));
      decSrcUse[1] = (fd == 1 || fd == 3 || fd == 4 || fd == 7);
      decIsBranch = (fd == BR_SLOT);
      decBrTaken = (fd == BR_SLOT) && (brDone < n - 1);
      exRd = IDX_W'(rdOf(ex)); exWe = (rdOf(ex) != 0);
      memRd = IDX_W'(rdOf(mem)); memWe = (rdOf(mem) != 0);
      #1;
      monitorPop();
      wb = mem;
      mem = ex;
      if (holdPc) begin
        ex = -1;
      end else begin
        ex = fd;
        if (fd == BR_SLOT) brDone++;
        if (squashFd) begin
          fd = -1;
          pc = 0;
        end else begin
          fd = (pc > BR_SLOT) ? BR_SLOT + 1 : pc;
          pc++;
        end
      end
    end
    chk($sformatf("R12 total cycles for %0d iterations", n), doneCyc, PERIOD * n + 3);
    expQ.delete();
  endtask

  initial begin
    #(WATCHDOG * 4);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R10 outputs in reset", outs(), 0);
    @(negedge clk);
    rstN = 1'b1;

    //        req                          v  s0 u0 s1 u1 br tk er ew mr mw  exp
    directed("R1 source A vs execute",     1, 3, 1, 0, 0, 0, 0, 3, 1, 0, 0, 4'b1110);
    directed("R1 source B vs execute",     1, 6, 1, 7, 1, 0, 0, 7, 1, 0, 0, 4'b1110);
    directed("R2 source B vs memory",      1, 6, 1, 7, 1, 0, 0, 2, 1, 7, 1, 4'b1110);
    directed("R2 source A vs memory",      1, 12,1, 0, 0, 0, 0, 0, 0, 12,1, 4'b1110);
    directed("R3 producer past memory",    1, 9, 1, 8, 1, 0, 0, 4, 1, 10,1, 4'b0000);
    directed("R4 index zero execute",      1, 0, 1, 0, 1, 0, 0, 0, 1, 0, 1, 4'b0000);
    directed("R5 unused source",           1, 5, 0, 0, 0, 0, 0, 5, 1, 5, 1, 4'b0000);
    directed("R5 write enable low",        1, 5, 1, 0, 0, 0, 0, 5, 0, 5, 0, 4'b0000);
    directed("R6 hold strobes grouped",    1, 1, 1, 2, 1, 0, 0, 0, 0, 2, 1, 4'b1110);
    directed("R7 taken branch squashes",   1, 5, 1, 0, 0, 1, 1, 4, 1, 6, 1, 4'b0001);
    directed("R8 stall beats squash",      1, 5, 1, 0, 0, 1, 1, 4, 1, 5, 1, 4'b1110);
    directed("R8 stall beats squash ex",   1, 5, 1, 0, 0, 1, 1, 5, 1, 0, 0, 4'b1110);
    directed("R9 not-taken branch",        1, 5, 1, 0, 0, 1, 0, 4, 1, 6, 1, 4'b0000);
    directed("R10 empty decode",           0, 5, 1, 5, 1, 1, 1, 5, 1, 5, 1, 4'b0000);

    runLoop(1);
    runLoop(3);
    runLoop(54);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule